// File: doc/BRIEF.md
# Multi-Rate LED Blink Generator

This block drives a single LED from a slow timebase. It sees only a tick enable, nominally 32768 pulses per second, and it counts those pulses. It never measures absolute time. The tick can come from an external crystal, from a divided-down fast clock, or from an on-chip ring oscillator. When the ring oscillator is used, the real blink rates can drop to roughly a third of nominal, and the pattern keeps its shape because every length is a tick count.

A 3-bit rate field selects one of eight patterns: steady off, six blink rates, or steady on. The blink rates are 0.25, 0.5, 1, 2, 3 and 4 Hz. Each rate has its own on-time fraction. A 1-bit run control forces the LED off whatever the rate field says.

Each blink period opens with the LED lit. A change from one blink rate to another waits for the running period to finish, so no shortened pulse is ever produced. Steady patterns take over at the next clock. When the block leaves a steady pattern for a blink rate, it starts a fresh period at once.

Top module: `led_blink_gen`

## Requirements
- R1: While reset is asserted, the LED output is low. After reset is released, the block is idle with its tick count at zero, and the LED stays low until a blink rate or steady-on is selected.
- R2: The LED is low from the next clock edge whenever run_mode is 0 or rate_sel is 3'b000. This does not depend on the tick input.
- R3: With run_mode at 1 and rate_sel at 3'b111, the LED is high from the next clock edge. This does not depend on the tick input.
- R4: For codes 1 to 6 the period length is P = round(4·BASE_HZ / q) ticks, with q = 1, 2, 4, 8, 12, 16 for code 1 to code 6. The codes stand for 0.25, 0.5, 1, 2, 3 and 4 Hz. The default BASE_HZ of 32768 gives 131072, 65536, 32768, 16384, 10923 and 8192 ticks.
- R5: The on-time is floor(4·BASE_HZ/10) ticks for code 1 (10 %) and floor(4·BASE_HZ/(4q)) ticks for code 2 (25 %). For codes 3 to 6 it is floor(4·BASE_HZ/(2q)) ticks (50 %). The defaults are 13107, 16384, 16384, 8192, 5461 and 4096.
- R6: Every period begins with the LED high. The LED stays high for exactly the on-time in ticks and then stays low until the period ends.
- R7: The pattern advances only on clock edges where tick_en is high. With tick_en low, the LED level and the position within the period do not change.
- R8: When one blink code replaces another, the old pattern runs until its period wraps. The code present on rate_sel at the wrapping tick is the one that takes effect.
- R9: A blink code selected while the block is idle starts a new period at the next clock edge, without waiting for a tick. The LED is high from that edge on. The block is idle after reset or while a steady pattern is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle pulse per timebase tick |
| run_mode | input | 1 | 1 = follow rate_sel, 0 = LED forced off |
| rate_sel | input | 3 | Pattern code: 0 off, 1..6 blink rates, 7 steady on |
| led | output | 1 | Registered LED drive, high = lit |

## Verification
The embedded properties check the following on every cycle:
- the steady-off and steady-on responses one edge after their selection;
- the counter bounds;
- that the latched rate is held between period wraps;
- that the count is frozen on cycles without a tick;
- that a period opens with the LED lit.

Exact on-time and period lengths for each code, with dense, sparse and irregular tick patterns, can only be shown by the bench scenarios. The same holds for the deferred switch between two blink rates and for a reset arriving during a blink. The bench compares these against a tick-by-tick model on a small timebase.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  typedef logic [2:0] rate_code_t;

  localparam rate_code_t CODE_DARK = 3'd0;
  localparam rate_code_t CODE_LIT  = 3'd7;

  // Rate multiplier q: nominal blink frequency times four.
  function automatic int unsigned rate_q(input rate_code_t c);
    case (c)
      3'd1:    rate_q = 1;
      3'd2:    rate_q = 2;
      3'd3:    rate_q = 4;
      3'd4:    rate_q = 8;
      3'd5:    rate_q = 12;
      3'd6:    rate_q = 16;
      default: rate_q = 1;
    endcase
  endfunction

  // Period in ticks, rounded to nearest.
  function automatic int unsigned period_ticks(input int unsigned base_hz, input rate_code_t c);
    int unsigned q;
    q = rate_q(c);
    period_ticks = (base_hz * 4 + q / 2) / q;
  endfunction

  // On-time in ticks: 10 % for code 1, 25 % for code 2, 50 % otherwise.
  function automatic int unsigned on_ticks(input int unsigned base_hz, input rate_code_t c);
    int unsigned q;
    q = rate_q(c);
    if (c == 3'd1)      on_ticks = (base_hz * 4) / 10;
    else if (c == 3'd2) on_ticks = (base_hz * 4) / (q * 4);
    else                on_ticks = (base_hz * 4) / (q * 2);
  endfunction

endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/led_rate_table.sv
module led_rate_table #(
  parameter int unsigned BASE_HZ = 32768,
  parameter int unsigned CW      = 18
) (
  input  led_blink_pkg::rate_code_t code_now_i,
  input  led_blink_pkg::rate_code_t code_next_i,
  output logic [CW-1:0]             period_now_o,
  output logic [CW-1:0]             on_next_o
);
  logic [CW-1:0] per_tab [8];
  logic [CW-1:0] on_tab  [8];

  for (genvar g = 0; g < 8; g++) begin : g_entry
    localparam int unsigned PER = led_blink_pkg::period_ticks(BASE_HZ, 3'(g));
    localparam int unsigned ONT = led_blink_pkg::on_ticks(BASE_HZ, 3'(g));
    assign per_tab[g] = CW'(PER);
    assign on_tab[g]  = CW'(ONT);
  end

  assign period_now_o = per_tab[code_now_i];
  assign on_next_o    = on_tab[code_next_i];
endmodule

// File: rtl/led_period_ctr.sv
module led_period_ctr #(
  parameter int unsigned CW = 18
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic                      blink_req_i,
  input  led_blink_pkg::rate_code_t sel_i,
  input  logic [CW-1:0]             period_i,
  output logic [CW-1:0]             cnt_q,
  output led_blink_pkg::rate_code_t act_q,
  output logic [CW-1:0]             cnt_n,
  output led_blink_pkg::rate_code_t act_n
);
  import led_blink_pkg::*;

  logic wrap;
  logic idle;

  assign idle = (act_q == CODE_DARK);
  assign wrap = (cnt_q == period_i - CW'(1));

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (!blink_req_i) begin
      cnt_n = '0;
      act_n = CODE_DARK;
    end else if (idle) begin
      cnt_n = '0;
      act_n = sel_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_n = '0;
        act_n = sel_i;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= CODE_DARK;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle) |-> (cnt_q < period_i));

  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && blink_req_i && !(tick_i && wrap)) |=> $stable(act_q));

  // R7
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && blink_req_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/led_drive.sv
module led_drive #(
  parameter int unsigned CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          steady_i,
  input  logic          steady_val_i,
  input  logic [CW-1:0] cnt_n_i,
  input  logic [CW-1:0] on_n_i,
  output logic          led_o
);
  logic led_n;

  always_comb begin
    if (steady_i) led_n = steady_val_i;
    else          led_n = (cnt_n_i < on_n_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_o <= 1'b0;
    else        led_o <= led_n;
  end
endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int unsigned BASE_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       run_mode,
  input  logic [2:0] rate_sel,
  output logic       led
);
  import led_blink_pkg::*;

  localparam int unsigned CW = $clog2(BASE_HZ * 4 + 1);

  logic          srst_n;
  logic          steady;
  logic          steady_val;
  logic          blink_req;
  logic [CW-1:0] cnt_q, cnt_n;
  rate_code_t    act_q, act_n;
  logic [CW-1:0] period_now;
  logic [CW-1:0] on_next;

  assign steady     = !run_mode || (rate_sel == CODE_DARK) || (rate_sel == CODE_LIT);
  assign steady_val = run_mode && (rate_sel == CODE_LIT);
  assign blink_req  = !steady;

  led_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  led_rate_table #(.BASE_HZ(BASE_HZ), .CW(CW)) u_table (
    .code_now_i   (act_q),
    .code_next_i  (act_n),
    .period_now_o (period_now),
    .on_next_o    (on_next)
  );

  led_period_ctr #(.CW(CW)) u_ctr (
    .clk         (clk),
    .rst_n       (srst_n),
    .tick_i      (tick_en),
    .blink_req_i (blink_req),
    .sel_i       (rate_sel),
    .period_i    (period_now),
    .cnt_q       (cnt_q),
    .act_q       (act_q),
    .cnt_n       (cnt_n),
    .act_n       (act_n)
  );

  led_drive #(.CW(CW)) u_drive (
    .clk          (clk),
    .rst_n        (srst_n),
    .steady_i     (steady),
    .steady_val_i (steady_val),
    .cnt_n_i      (cnt_n),
    .on_n_i       (on_next),
    .led_o        (led)
  );

  // R2
  dark_sel_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!run_mode || rate_sel == CODE_DARK) |=> !led);

  // R3
  lit_sel_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (run_mode && rate_sel == CODE_LIT) |=> led);

  // R6
  period_open_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (act_q != CODE_DARK && cnt_q == '0) |-> led);

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    (!srst_n) |-> !led);
endmodule

// File: tb/led_blink_gen_test.sv
`timescale 1ns/1ps
module led_blink_gen_test;
  localparam int unsigned BASE = 48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       run_mode;
  logic [2:0] rate_sel;
  logic       led;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic       nxt_run;
  logic [2:0] nxt_sel;
  int         m_act;
  int         m_k;
  logic       m_led;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  led_blink_gen #(.BASE_HZ(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .run_mode(run_mode), .rate_sel(rate_sel), .led(led)
  );

  // Expected lengths from R4 and R5.
  function automatic int q_of(input int c);
    int t [7] = '{1, 1, 2, 4, 8, 12, 16};
    return t[c];
  endfunction
  function automatic int exp_per(input int c);
    return (4 * BASE + q_of(c) / 2) / q_of(c);
  endfunction
  function automatic int exp_on(input int c);
    if (c == 1) return (4 * BASE) / 10;
    if (c == 2) return (4 * BASE) / (4 * q_of(c));
    return (4 * BASE) / (2 * q_of(c));
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: led=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Tick-by-tick model from R2, R3, R6, R7, R8, R9.
  task automatic model_step(input logic r, input logic [2:0] s, input logic t);
    if (!r || s == 3'd0 || s == 3'd7) begin
      m_act = 0; m_k = 0; m_led = r && (s == 3'd7);
    end else if (m_act == 0) begin
      m_act = int'(s); m_k = 0; m_led = 1'b1;
    end else begin
      if (t) begin
        if (m_k == exp_per(m_act) - 1) begin
          m_k = 0; m_act = int'(s);
        end else m_k++;
      end
      m_led = (m_k < exp_on(m_act));
    end
  endtask

  // tmode: 0 every cycle, 1 irregular, 2 never, 3 every third cycle
  task automatic run(input int n, input int tmode, input string tag);
    for (int i = 0; i < n; i++) begin
      logic t;
      @(negedge clk);
      check(led, m_led, tag);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (tmode)
        0: t = 1'b1;
        1: t = lfsr[0];
        2: t = 1'b0;
        default: t = (i % 3 == 0);
      endcase
      tick_en  = t;
      run_mode = nxt_run;
      rate_sel = nxt_sel;
      @(posedge clk);
      model_step(run_mode, rate_sel, t);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; run_mode = 1'b1; rate_sel = 3'd3;
    nxt_run = 1'b1; nxt_sel = 3'd0;
    m_act = 0; m_k = 0; m_led = 1'b0;
    // R1: held in reset with a blink code selected
    repeat (3) begin
      @(negedge clk);
      check(led, 1'b0, "R1");
    end
    rate_sel = 3'd0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run(4, 0, "R1");

    // R4 R5 R6: every blink code with a tick on every cycle, then sparse ticks for R7
    for (int c = 1; c <= 6; c++) begin
      nxt_sel = 3'(c);
      run(2 * exp_per(c) + 3, 0, "R4/R5/R6");
      run(exp_per(c) * 2, 1, "R7");
      run(exp_per(c), 3, "R7");
      nxt_sel = 3'd0;
      run(3, 1, "R2");
    end

    // R7: ticks held off mid-blink
    nxt_sel = 3'd5;
    run(5, 0, "R9");
    run(40, 2, "R7");
    run(20, 0, "R7");

    // R3 and R2 with run_mode low
    nxt_sel = 3'd7;
    run(6, 1, "R3");
    nxt_run = 1'b0;
    run(6, 1, "R2");
    nxt_run = 1'b1;
    run(3, 0, "R3");

    // R9: leave steady-on for a blink code
    nxt_sel = 3'd4;
    run(3, 2, "R9");
    run(30, 0, "R9");

    // R8: switch between blink codes mid-period
    nxt_sel = 3'd6;
    run(3, 0, "R8");
    nxt_sel = 3'd1;
    run(2 * exp_per(1) + 10, 0, "R8");
    nxt_sel = 3'd3;
    run(exp_per(1) + 2 * exp_per(3), 1, "R8");
    nxt_sel = 3'd2;
    run(40, 0, "R8");
    nxt_sel = 3'd5;
    run(2 * exp_per(2), 0, "R8");

    // R1: reset arriving during a blink
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(led, 1'b0, "R1");
    nxt_sel = 3'd0;
    rate_sel = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    m_act = 0; m_k = 0; m_led = 1'b0;
    run(4, 0, "R1");
    nxt_sel = 3'd6;
    run(2 * exp_per(6), 0, "R1/R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule